// File: doc/BRIEF.md
# Out-of-Order Issue Scheduler with In-Order Retirement

This block takes decoded register-to-register instructions, one per cycle and in program order, and holds them in a small circular window. Each slot records whether its two operands are present. A missing operand is represented by the slot number of the instruction that will produce it. An adder that finishes in one cycle and a four-cycle multiplier take work from the window. A single result bus carries each finished value together with its producer slot number. Slots that wait on that producer capture the value from the bus.

By default, the oldest slot whose operands are present and whose unit can accept work is sent to that unit, even when older slots are still waiting. Raising `in_order` makes selection stop at the oldest slot that has not yet been sent, so one stalled instruction holds back every younger one. Whichever order is used for execution, results leave the window and update the register file strictly in program order. This keeps architectural state precise. A free-running cycle counter lets the two modes be compared on the same instruction stream.

Top module: `ooo_sched`

## Requirements
- R1: After reset `in_ready` is 1, `ret_valid` is 0, `cycle_count` is 0, and architectural register i holds the value i.
- R2: Opcode 0 writes the sum of the two sources and opcode 1 writes their product; both keep only the low XLEN bits.
- R3: Every accepted instruction appears exactly once on the retire port, with its destination and result, in the order it was accepted.
- R4: An instruction that reads a register written by an older instruction still in flight receives that older instruction's result.
- R5: A later write to a register never changes the value seen by an older reader of that register, and a register's final value comes from the youngest writer.
- R6: `in_ready` is 0 exactly when 8 accepted instructions have not yet retired.
- R7: With `in_order` at 1, results are identical to those of the default mode.
- R8: For a stream in which a multiply feeds the next instruction and independent work follows, the default mode retires everything in fewer cycles than in-order mode.
- R9: When the multiplier and the adder finish in the same cycle, the multiplier's result takes the bus and the adder's result is kept and sent one cycle later, with no result lost.
- R10: `cycle_count` increases by exactly one every clock cycle after reset.
- R11: In an otherwise idle block, an add accepted at a clock edge is shown on the retire port 2 cycles later, and a multiply 5 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_order | input | 1 | 1 selects stalling in-order selection |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Window has room; accepted when both are high at a clock edge |
| in_op | input | 1 | 0 add, 1 multiply |
| in_dst | input | 3 | Destination register |
| in_src_a | input | 3 | First source register |
| in_src_b | input | 3 | Second source register |
| ret_valid | output | 1 | Oldest instruction retires at the coming edge |
| ret_dst | output | 3 | Destination of the retiring instruction |
| ret_value | output | 16 | Result of the retiring instruction |
| cycle_count | output | 32 | Cycles since reset |

## Verification
Completion from the multiplier and the adder can land in the same cycle on the single result bus. The bench forces this by feeding a multiply followed at once by a run of independent adds. The third add then finishes in the multiplier's final cycle. The check is that each of those instructions retires in order with the value a sequential reference model predicts: an add result dropped or overwritten while held would show up as a wrong or missing retirement. A second same-cycle case is allocation of a reader in the very cycle its producer broadcasts or retires. Dependent chains are sent back to back so that this happens repeatedly.

// File: rtl/ooo_sched.sv
module ooo_sched #(
  parameter int XLEN = 16,
  parameter int NREG = 8,
  parameter int WIN = 8,
  parameter int MUL_LAT = 4,
  localparam int RW = $clog2(NREG),
  localparam int TW = $clog2(WIN),
  localparam int CW = $clog2(WIN + 1),
  localparam int MW = $clog2(MUL_LAT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_order,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_op,
  input  logic [RW-1:0]   in_dst,
  input  logic [RW-1:0]   in_src_a,
  input  logic [RW-1:0]   in_src_b,
  output logic            ret_valid,
  output logic [RW-1:0]   ret_dst,
  output logic [XLEN-1:0] ret_value,
  output logic [31:0]     cycle_count
);

  logic [XLEN-1:0] arf [NREG];
  logic [NREG-1:0] rat_busy;
  logic [TW-1:0]   rat_tag [NREG];

  logic [WIN-1:0]  e_v, e_iss, e_done, e_op, e_ra, e_rb;
  logic [RW-1:0]   e_dst [WIN];
  logic [TW-1:0]   e_ta [WIN];
  logic [TW-1:0]   e_tb [WIN];
  logic [XLEN-1:0] e_va [WIN];
  logic [XLEN-1:0] e_vb [WIN];
  logic [XLEN-1:0] e_res [WIN];

  logic [TW-1:0] head, tail;
  logic [CW-1:0] count;

  logic            add_v;
  logic [TW-1:0]   add_tag;
  logic [XLEN-1:0] add_res;
  logic            mul_busy;
  logic [MW-1:0]   mul_cnt;
  logic [TW-1:0]   mul_tag;
  logic [XLEN-1:0] mul_res;

  logic            mul_fin, add_free, mul_free, alloc;
  logic            bc_v;
  logic [TW-1:0]   bc_tag;
  logic [XLEN-1:0] bc_val;

  assign mul_fin  = mul_busy && (mul_cnt == MW'(MUL_LAT));
  assign add_free = !add_v || !mul_fin;
  assign mul_free = !mul_busy || mul_fin;
  assign bc_v     = mul_fin || add_v;
  assign bc_tag   = mul_fin ? mul_tag : add_tag;
  assign bc_val   = mul_fin ? mul_res : add_res;

  assign in_ready  = count < CW'(WIN);
  assign alloc     = in_valid && in_ready;
  assign ret_valid = e_v[head] && e_done[head];
  assign ret_dst   = e_dst[head];
  assign ret_value = e_res[head];

  logic [RW-1:0]   src [2];
  logic            op_rdy [2];
  logic [TW-1:0]   op_tag [2];
  logic [XLEN-1:0] op_val [2];

  assign src[0] = in_src_a;
  assign src[1] = in_src_b;

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      op_tag[k] = rat_tag[src[k]];
      op_rdy[k] = 1'b1;
      op_val[k] = arf[src[k]];
      if (rat_busy[src[k]]) begin
        if (e_done[op_tag[k]]) begin
          op_val[k] = e_res[op_tag[k]];
        end else if (bc_v && bc_tag == op_tag[k]) begin
          op_val[k] = bc_val;
        end else begin
          op_rdy[k] = 1'b0;
          op_val[k] = '0;
        end
      end
    end
  end

  logic          iss;
  logic [TW-1:0] iss_idx;

  always_comb begin
    logic          blk;
    logic [TW-1:0] slot;
    iss     = 1'b0;
    iss_idx = head;
    blk     = 1'b0;
    for (int k = 0; k < WIN; k++) begin
      slot = head + TW'(k);
      if (!blk && e_v[slot] && !e_iss[slot]) begin
        if (e_ra[slot] && e_rb[slot] && (e_op[slot] ? mul_free : add_free)) begin
          iss     = 1'b1;
          iss_idx = slot;
          blk     = 1'b1;
        end else if (in_order) begin
          blk = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_v <= '0; e_iss <= '0; e_done <= '0; e_op <= '0; e_ra <= '0; e_rb <= '0;
      for (int i = 0; i < WIN; i++) begin
        e_dst[i] <= '0; e_ta[i] <= '0; e_tb[i] <= '0;
        e_va[i]  <= '0; e_vb[i] <= '0; e_res[i] <= '0;
      end
    end else begin
      for (int i = 0; i < WIN; i++) begin
        if (ret_valid && head == TW'(i)) e_v[i] <= 1'b0;
        if (bc_v && e_v[i] && !e_ra[i] && e_ta[i] == bc_tag) begin
          e_ra[i] <= 1'b1;
          e_va[i] <= bc_val;
        end
        if (bc_v && e_v[i] && !e_rb[i] && e_tb[i] == bc_tag) begin
          e_rb[i] <= 1'b1;
          e_vb[i] <= bc_val;
        end
        if (bc_v && bc_tag == TW'(i)) begin
          e_done[i] <= 1'b1;
          e_res[i]  <= bc_val;
        end
        if (iss && iss_idx == TW'(i)) e_iss[i] <= 1'b1;
        if (alloc && tail == TW'(i)) begin
          e_v[i]    <= 1'b1;
          e_iss[i]  <= 1'b0;
          e_done[i] <= 1'b0;
          e_op[i]   <= in_op;
          e_dst[i]  <= in_dst;
          e_ra[i]   <= op_rdy[0];
          e_ta[i]   <= op_tag[0];
          e_va[i]   <= op_val[0];
          e_rb[i]   <= op_rdy[1];
          e_tb[i]   <= op_tag[1];
          e_vb[i]   <= op_val[1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rat_busy <= '0;
      for (int i = 0; i < NREG; i++) begin
        arf[i]     <= XLEN'(i);
        rat_tag[i] <= '0;
      end
    end else begin
      if (ret_valid) begin
        arf[ret_dst] <= ret_value;
        if (rat_busy[ret_dst] && rat_tag[ret_dst] == head) rat_busy[ret_dst] <= 1'b0;
      end
      if (alloc) begin
        rat_busy[in_dst] <= 1'b1;
        rat_tag[in_dst]  <= tail;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      count <= '0;
      cycle_count <= '0;
    end else begin
      cycle_count <= cycle_count + 32'd1;
      if (ret_valid) head <= head + TW'(1);
      if (alloc) tail <= tail + TW'(1);
      case ({alloc, ret_valid})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      add_v <= 1'b0; add_tag <= '0; add_res <= '0;
      mul_busy <= 1'b0; mul_cnt <= '0; mul_tag <= '0; mul_res <= '0;
    end else begin
      if (add_v && !mul_fin) add_v <= 1'b0;
      if (iss && !e_op[iss_idx]) begin
        add_v   <= 1'b1;
        add_tag <= iss_idx;
        add_res <= e_va[iss_idx] + e_vb[iss_idx];
      end
      if (mul_fin) mul_busy <= 1'b0;
      else if (mul_busy) mul_cnt <= mul_cnt + MW'(1);
      if (iss && e_op[iss_idx]) begin
        mul_busy <= 1'b1;
        mul_cnt  <= MW'(1);
        mul_tag  <= iss_idx;
        mul_res  <= e_va[iss_idx] * e_vb[iss_idx];
      end
    end
  end

endmodule

// File: rtl/ooo_sched_chk.sv
module ooo_sched_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        ret_valid,
  input logic [31:0] cycle_count,
  input logic        mul_fin,
  input logic        mul_busy,
  input logic        add_v
);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (in_ready && !ret_valid && cycle_count == 32'd0)); // R1

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !ret_valid) |=> !in_ready); // R6

  AST_ADD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_fin && add_v) |=> add_v); // R9

  AST_MUL_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    mul_fin |-> ($past(mul_busy, 1) && $past(mul_busy, 3))); // R11

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cycle_count == $past(cycle_count) + 32'd1); // R10

endmodule

bind ooo_sched ooo_sched_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .in_ready(in_ready),
  .ret_valid(ret_valid),
  .cycle_count(cycle_count),
  .mul_fin(mul_fin),
  .mul_busy(mul_busy),
  .add_v(add_v)
);

// File: tb/ooo_sched_tb.sv
module ooo_sched_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_order = 1'b0, in_valid = 1'b0, in_op = 1'b0;
  logic [2:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic in_ready, ret_valid;
  logic [2:0] ret_dst;
  logic [15:0] ret_value;
  logic [31:0] cycle_count;

  always #(CLK_P/2) clk = ~clk;

  ooo_sched u_dut (
    .clk(clk), .rst_n(rst_n), .in_order(in_order), .in_valid(in_valid),
    .in_ready(in_ready), .in_op(in_op), .in_dst(in_dst), .in_src_a(in_src_a),
    .in_src_b(in_src_b), .ret_valid(ret_valid), .ret_dst(ret_dst),
    .ret_value(ret_value), .cycle_count(cycle_count)
  );

  int checks = 0, fails = 0, outst = 0;
  bit done = 1'b0, saw_full = 1'b0;
  string cur_req = "R3";
  logic [15:0] ref_r [8];
  logic [2:0]  q_dst [$];
  logic [15:0] q_val [$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(in_ready == (outst < 8), "R6", in_ready, outst < 8);
      if (!in_ready) saw_full = 1'b1;
      if (ret_valid) begin
        if (q_dst.size() == 0) begin
          check(1'b0, {cur_req, " extra retire"}, ret_dst, -1);
        end else begin
          logic [2:0] d;
          logic [15:0] v;
          d = q_dst.pop_front();
          v = q_val.pop_front();
          check(ret_dst == d, {cur_req, " R3 dst"}, ret_dst, d);
          check(ret_value == v, {cur_req, " value"}, ret_value, v);
        end
      end
      outst = outst + ((in_valid && in_ready) ? 1 : 0) - (ret_valid ? 1 : 0);
    end
  end

  task automatic sync();
    @(posedge clk); #1;
  endtask

  task automatic send(input bit op, input int d, input int a, input int b);
    logic [15:0] v;
    v = op ? 16'(ref_r[a] * ref_r[b]) : 16'(ref_r[a] + ref_r[b]);
    ref_r[d] = v;
    q_dst.push_back(3'(d));
    q_val.push_back(v);
    in_valid = 1'b1; in_op = op;
    in_dst = 3'(d); in_src_a = 3'(a); in_src_b = 3'(b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    do sync(); while (outst != 0);
  endtask

  task automatic latency(input bit op, input int exp);
    int k = 0;
    sync();
    send(op, 4, 4, 1);
    @(negedge clk);
    while (!ret_valid && k < 50) begin k++; @(negedge clk); end
    check(k == exp, "R11 latency", k, exp);
  endtask

  task automatic prog();
    send(1, 3, 1, 2);
    send(0, 3, 3, 1);
    send(0, 1, 6, 7);
    send(1, 5, 6, 2);
    send(0, 7, 4, 4);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int c0, t_ooo, t_ino;
    for (int i = 0; i < 8; i++) ref_r[i] = 16'(i);
    #(CLK_P * 3);
    check(in_ready == 1'b1, "R1 ready", in_ready, 1);
    check(ret_valid == 1'b0, "R1 ret_valid", ret_valid, 0);
    check(cycle_count == 0, "R1 count", cycle_count, 0);
    @(negedge clk); rst_n = 1'b1;

    cur_req = "R1";
    sync(); send(0, 0, 5, 0); send(0, 6, 6, 2); drain();

    latency(1'b0, 2);
    drain();
    latency(1'b1, 5);
    drain();

    @(negedge clk); c0 = int'(cycle_count);
    repeat (10) @(negedge clk);
    check(cycle_count == 32'(c0 + 10), "R10", cycle_count, c0 + 10);

    cur_req = "R4 R5 R8";
    in_order = 1'b0;
    sync(); c0 = int'(cycle_count);
    prog(); drain();
    t_ooo = int'(cycle_count) - c0;

    cur_req = "R7";
    in_order = 1'b1;
    sync(); c0 = int'(cycle_count);
    prog(); drain();
    t_ino = int'(cycle_count) - c0;
    check(t_ooo < t_ino, "R8 cycles", t_ooo, t_ino);

    cur_req = "R9";
    in_order = 1'b0;
    sync();
    send(1, 2, 3, 4);
    send(0, 5, 6, 7);
    send(0, 6, 0, 1);
    send(0, 7, 4, 4);
    send(0, 0, 1, 1);
    drain();

    cur_req = "R2 R6";
    saw_full = 1'b0;
    sync();
    for (int i = 0; i < 12; i++) send(1, 2, 2, 3);
    drain();
    check(saw_full, "R6 full seen", saw_full, 1);
    send(0, 1, 2, 2);
    send(1, 3, 2, 2);
    drain();
    check(q_dst.size() == 0, "R3 all retired", q_dst.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule